// File: doc/BRIEF.md
# Serial Slave Front End with Pause and Strap-Selected Address

This block is the serial-bus face of a small register-based peripheral. It watches a serial clock, a serial data input, an active-low select and an active-low pause line. It runs in the system clock domain: all four bus lines are synchronized, and their edges are detected there. Every frame opens with an address byte. The upper six bits of that byte are a fixed identifier and the lower two bits must equal two strap pins, so up to four of these devices can share one bus.

When the address matches, the next byte is an instruction. It is handed to the register core with a one-cycle strobe. The instruction's top bit chooses the direction of the data bytes that follow. In a write, each data byte is delivered with its own strobe. In a read, the block asks the core for a byte and shifts it out MSB first on the serial output, together with a drive-enable for an external tri-state buffer.

The pause line freezes a frame mid-byte without losing its place. Raising the select line abandons the frame. After reset, the block ignores the bus until it has seen the select line go from high to low.

Top module: `spi_hold_slave`

## Requirements
- R1: Serial data is taken on each rising edge of SCK, MSB first. The serial output changes only on falling edges of SCK.
- R2: While CS is high, so_oe_o is 0 and no frame is in progress. Raising CS in the middle of a frame discards it, and the next frame starts again from its address byte.
- R3: After reset, nothing on the bus has any effect, and no strobe or output enable appears, until CS has gone from high to low. That falling edge both arms the block and opens a frame.
- R4: The first byte of a frame must equal {6'b010100, strap_i[1:0]}. On a mismatch in any bit, the rest of the frame produces no strobe and no output enable.
- R5: The byte after a matching address is the instruction. instr_valid_o is high for exactly one clock with the byte on instr_o. Bit 7 = 1 makes the data phase a read, and bit 7 = 0 makes it a write.
- R6: In a write frame, each complete data byte raises wr_valid_o for one clock with the byte on wr_data_o.
- R7: In a read frame, rd_req_o pulses once after the instruction byte and once after each complete data byte. rd_data_i is taken one clock after the pulse. That byte appears on so_o MSB first over the next eight bits, and so_oe_o is 1 throughout the data phase.
- R8: A falling edge of HOLD while SCK is low pauses the frame, and a rising edge of HOLD while SCK is low resumes it. While paused, SCK edges change nothing and so_oe_o is 0. After resuming, the frame continues from the same bit.
- R9: An edge of HOLD that arrives while SCK is high has no effect on the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the bus master |
| si_i | input | 1 | Serial data in |
| cs_n_i | input | 1 | Active-low select |
| hold_n_i | input | 1 | Active-low pause |
| strap_i | input | 2 | Low address bits set by board straps |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Drive enable for the serial output buffer |
| instr_valid_o | output | 1 | One-clock strobe for a received instruction |
| instr_o | output | 8 | Received instruction byte |
| wr_valid_o | output | 1 | One-clock strobe for a received write byte |
| wr_data_o | output | 8 | Received write byte |
| rd_req_o | output | 1 | One-clock request for the next read byte |
| rd_data_i | input | 8 | Read byte from the core, taken one clock after rd_req_o |

## Verification
Each bus line reaches the frame logic after two synchronizer flops. One more register then produces each strobe and each change of the serial output, so every result is due three to four clocks after the bus edge that caused it. The bench holds each SCK phase for eight clocks and samples so_o and so_oe_o on the last clock of the low phase, well after the preceding falling edge has taken effect. Strobes are collected by a monitor on the falling clock edge and compared once each frame ends. Pause checks are sampled eight clocks after the HOLD edge, so the synchronized edge has landed before the output enable is read.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
   typedef enum logic [1:0] {
      ST_ADDR  = 2'd0,
      ST_INSTR = 2'd1,
      ST_DATA  = 2'd2,
      ST_SKIP  = 2'd3
   } frame_st_e;

   localparam int LINE_CS   = 0;
   localparam int LINE_HOLD = 1;
   localparam int LINE_SCK  = 2;
   localparam int LINE_SI   = 3;
   localparam int N_LINES   = 4;
endpackage

// File: rtl/spi_line_sync.sv
module spi_line_sync #(
   parameter int           WIDTH   = 4,
   parameter int           STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] lvl
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_line_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else if (s == 0) chain[s] <= din;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign lvl = chain[STAGES-1];
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          si_s,
   input  logic          step_rise,
   input  logic          step_fall,
   input  logic          tx_load,
   input  logic          rd_phase,
   input  logic [BW-1:0] rd_data,
   output logic [BW-1:0] rx_byte,
   output logic          so_o
);
   logic [BW-2:0] rx_q;
   logic [BW-1:0] tx_q;
   logic          so_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_q <= '0;
      else if (step_rise) rx_q <= {rx_q[BW-3:0], si_s};
   end

   assign rx_byte = {rx_q, si_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
         so_q <= 1'b0;
      end else if (tx_load) begin
         tx_q <= rd_data;
      end else if (step_fall && rd_phase) begin
         so_q <= tx_q[BW-1];
         tx_q <= {tx_q[BW-2:0], 1'b0};
      end
   end

   assign so_o = so_q;

   // R1: the output only moves on a falling-edge step of a read phase
   p_so_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_fall && rd_phase) |=> $stable(so_q));
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
   import spi_hold_pkg::*;
#(
   parameter int               BW      = 8,
   parameter int               ID_W    = 6,
   parameter int               STRAP_W = 2,
   parameter logic [ID_W-1:0]  DEV_ID  = 6'b010100
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] lvl,
   input  logic [STRAP_W-1:0] strap,
   input  logic [BW-1:0]      rx_byte,
   output logic               step_rise_o,
   output logic               step_fall_o,
   output logic               tx_load_o,
   output logic               rd_phase_o,
   output logic               so_oe_o,
   output logic               instr_valid_o,
   output logic [BW-1:0]      instr_o,
   output logic               wr_valid_o,
   output logic [BW-1:0]      wr_data_o,
   output logic               rd_req_o
);
   localparam int CNT_W = $clog2(BW);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BW-1);

   logic cs_n_s, hold_n_s, sck_s;
   logic cs_prv, hold_prv, sck_prv;
   logic cs_fall, hold_fall, hold_rise, sck_rise, sck_fall;
   logic armed_q, paused_q, active, byte_done, addr_hit;
   logic rd_mode_q;
   logic [CNT_W-1:0] bit_cnt;
   frame_st_e state_q;

   assign cs_n_s   = lvl[LINE_CS];
   assign hold_n_s = lvl[LINE_HOLD];
   assign sck_s    = lvl[LINE_SCK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prv   <= 1'b0;
         hold_prv <= 1'b1;
         sck_prv  <= 1'b0;
      end else begin
         cs_prv   <= cs_n_s;
         hold_prv <= hold_n_s;
         sck_prv  <= sck_s;
      end
   end

   assign cs_fall   = cs_prv & ~cs_n_s;
   assign hold_fall = hold_prv & ~hold_n_s;
   assign hold_rise = ~hold_prv & hold_n_s;
   assign sck_rise  = ~sck_prv & sck_s;
   assign sck_fall  = sck_prv & ~sck_s;

   // arming: first falling edge of select after reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else if (cs_fall) armed_q <= 1'b1;
   end

   assign active = (armed_q | cs_fall) & ~cs_n_s;

   // pause tracking, edges honoured only with the serial clock low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) paused_q <= 1'b0;
      else if (!active) paused_q <= 1'b0;
      else if (hold_fall && !sck_s) paused_q <= 1'b1;
      else if (hold_rise && !sck_s) paused_q <= 1'b0;
   end

   assign step_rise_o = active & ~paused_q & sck_rise;
   assign step_fall_o = active & ~paused_q & sck_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_cnt <= '0;
      else if (!active) bit_cnt <= '0;
      else if (step_rise_o) bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
   end

   assign byte_done = step_rise_o && (bit_cnt == LAST_BIT);
   assign addr_hit  = (rx_byte == {DEV_ID, strap});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_ADDR;
         rd_mode_q     <= 1'b0;
         instr_valid_o <= 1'b0;
         instr_o       <= '0;
         wr_valid_o    <= 1'b0;
         wr_data_o     <= '0;
         rd_req_o      <= 1'b0;
         tx_load_o     <= 1'b0;
      end else begin
         instr_valid_o <= 1'b0;
         wr_valid_o    <= 1'b0;
         rd_req_o      <= 1'b0;
         tx_load_o     <= rd_req_o;
         if (!active) begin
            state_q   <= ST_ADDR;
            rd_mode_q <= 1'b0;
         end else if (byte_done) begin
            unique case (state_q)
               ST_ADDR:  state_q <= addr_hit ? ST_INSTR : ST_SKIP;
               ST_INSTR: begin
                  state_q       <= ST_DATA;
                  rd_mode_q     <= rx_byte[BW-1];
                  instr_valid_o <= 1'b1;
                  instr_o       <= rx_byte;
                  rd_req_o      <= rx_byte[BW-1];
               end
               ST_DATA: begin
                  if (rd_mode_q) rd_req_o <= 1'b1;
                  else begin
                     wr_valid_o <= 1'b1;
                     wr_data_o  <= rx_byte;
                  end
               end
               default: state_q <= ST_SKIP;
            endcase
         end
      end
   end

   assign rd_phase_o = (state_q == ST_DATA) & rd_mode_q;
   assign so_oe_o    = active & ~paused_q & rd_phase_o;

   // R2: output never driven while deselected
   p_oe_off_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |-> !so_oe_o);
   // R3: nothing reaches the core before arming
   p_quiet_unarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |=> !instr_valid_o && !wr_valid_o && !rd_req_o);
   // R4: a foreign frame stays silent
   p_skip_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SKIP) |-> !instr_valid_o && !wr_valid_o && !rd_req_o && !so_oe_o);
   // R5: instruction strobe lasts one clock
   p_instr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid_o |=> !instr_valid_o);
   // R8: the bit position is frozen while paused
   p_hold_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (paused_q && !cs_n_s) |=> $stable(bit_cnt));
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave
   import spi_hold_pkg::*;
#(
   parameter int              BW          = 8,
   parameter int              ID_W        = 6,
   parameter int              STRAP_W     = 2,
   parameter logic [ID_W-1:0] DEV_ID      = 6'b010100,
   parameter int              SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck_i,
   input  logic               si_i,
   input  logic               cs_n_i,
   input  logic               hold_n_i,
   input  logic [STRAP_W-1:0] strap_i,
   output logic               so_o,
   output logic               so_oe_o,
   output logic               instr_valid_o,
   output logic [BW-1:0]      instr_o,
   output logic               wr_valid_o,
   output logic [BW-1:0]      wr_data_o,
   output logic               rd_req_o,
   input  logic [BW-1:0]      rd_data_i
);
   localparam logic [N_LINES-1:0] LINE_RST = N_LINES'(1 << LINE_HOLD);

   generate
      if (ID_W + STRAP_W != BW) begin : g_bad_width
         $error("identifier plus strap width must fill one byte");
      end
      if (BW < 3) begin : g_bad_bw
         $error("byte width too small");
      end
   endgenerate

   logic [N_LINES-1:0] raw, lvl;
   logic [BW-1:0]      rx_byte;
   logic step_rise, step_fall, tx_load, rd_phase;

   always_comb begin
      raw            = '0;
      raw[LINE_CS]   = cs_n_i;
      raw[LINE_HOLD] = hold_n_i;
      raw[LINE_SCK]  = sck_i;
      raw[LINE_SI]   = si_i;
   end

   spi_line_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(raw), .lvl(lvl));

   spi_frame_ctrl #(.BW(BW), .ID_W(ID_W), .STRAP_W(STRAP_W), .DEV_ID(DEV_ID)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .strap(strap_i), .rx_byte(rx_byte),
      .step_rise_o(step_rise), .step_fall_o(step_fall), .tx_load_o(tx_load),
      .rd_phase_o(rd_phase), .so_oe_o(so_oe_o), .instr_valid_o(instr_valid_o),
      .instr_o(instr_o), .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o),
      .rd_req_o(rd_req_o));

   spi_shifter #(.BW(BW)) u_shift (
      .clk(clk), .rst_n(rst_n), .si_s(lvl[LINE_SI]), .step_rise(step_rise),
      .step_fall(step_fall), .tx_load(tx_load), .rd_phase(rd_phase),
      .rd_data(rd_data_i), .rx_byte(rx_byte), .so_o(so_o));
endmodule

// File: tb/spi_hold_slave_bench.sv
module spi_hold_slave_bench;
   localparam int HALF = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, si = 1'b0, cs_n = 1'b0, hold_n = 1'b1;
   logic [1:0] strap = 2'd2;
   logic so, so_oe, instr_valid, wr_valid, rd_req;
   logic [7:0] instr, wr_data, rd_data = 8'h00;

   int checks = 0, fails = 0, cyc = 0;
   int n_instr = 0, n_wr = 0, n_rd = 0;
   logic [7:0] last_instr = 8'h00;
   logic [7:0] wr_log [8];
   bit done = 1'b0;

   always #2 clk = ~clk;

   spi_hold_slave u_spi_hold_slave (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .si_i(si), .cs_n_i(cs_n),
      .hold_n_i(hold_n), .strap_i(strap), .so_o(so), .so_oe_o(so_oe),
      .instr_valid_o(instr_valid), .instr_o(instr), .wr_valid_o(wr_valid),
      .wr_data_o(wr_data), .rd_req_o(rd_req), .rd_data_i(rd_data));

   function automatic logic [7:0] rd_val(int n);
      return 8'hC3 ^ (8'(n) * 8'd37);
   endfunction

   always @(negedge clk) begin
      cyc++;
      if (instr_valid) begin n_instr++; last_instr = instr; end
      if (wr_valid) begin wr_log[n_wr % 8] = wr_data; n_wr++; end
      if (rd_req) begin rd_data = rd_val(n_rd); n_rd++; end
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   // one bus bit: drive, hold low phase, sample output, rise, fall
   task automatic bus_bit(input logic b, output logic so_seen, output logic oe_seen);
      si = b;
      wait_clk(HALF);
      so_seen = so; oe_seen = so_oe;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
   endtask

   task automatic bus_byte(input logic [7:0] b, output logic [7:0] got, output logic oe_all);
      logic s, e;
      oe_all = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         bus_bit(b[i], s, e);
         got[i] = s;
         oe_all &= e;
      end
   endtask

   task automatic sel;
      cs_n = 1'b0; wait_clk(HALF);
   endtask

   task automatic desel;
      wait_clk(HALF); cs_n = 1'b1; wait_clk(2*HALF);
   endtask

   task automatic t_reset_unarmed;
      logic [7:0] g; logic e;
      check(so_oe == 1'b0, "R2 reset oe", so_oe, 0);
      bus_byte(8'h52, g, e);
      bus_byte(8'h05, g, e);
      bus_byte(8'h11, g, e);
      check(n_instr == 0, "R3 no instr before arming", n_instr, 0);
      check(n_wr == 0, "R3 no write before arming", n_wr, 0);
      check(e == 1'b0, "R3 no oe before arming", e, 0);
      desel();
   endtask

   task automatic t_write;
      logic [7:0] g; logic e;
      int i0 = n_instr, w0 = n_wr;
      sel();
      bus_byte(8'h52, g, e);
      bus_byte(8'h05, g, e);
      bus_byte(8'hA5, g, e);
      bus_byte(8'h3C, g, e);
      desel();
      check(n_instr == i0 + 1, "R5 one instr strobe", n_instr - i0, 1);
      check(last_instr == 8'h05, "R5 instr byte", last_instr, 8'h05);
      check(n_wr == w0 + 2, "R6 write count", n_wr - w0, 2);
      check(wr_log[w0 % 8] == 8'hA5, "R6 first write byte", wr_log[w0 % 8], 8'hA5);
      check(wr_log[(w0 + 1) % 8] == 8'h3C, "R1 MSB-first second byte", wr_log[(w0 + 1) % 8], 8'h3C);
   endtask

   task automatic t_mismatch(input logic [7:0] addr, input string tag);
      logic [7:0] g; logic e;
      int i0 = n_instr, w0 = n_wr, r0 = n_rd;
      sel();
      bus_byte(addr, g, e);
      bus_byte(8'h81, g, e);
      bus_byte(8'h77, g, e);
      desel();
      check(n_instr == i0 && n_wr == w0 && n_rd == r0, tag,
            (n_instr - i0) + (n_wr - w0) + (n_rd - r0), 0);
      check(e == 1'b0, "R4 no oe on mismatch", e, 0);
   endtask

   task automatic t_read;
      logic [7:0] g; logic e;
      int r0 = n_rd;
      sel();
      bus_byte(8'h52, g, e);
      bus_byte(8'h83, g, e);
      check(last_instr == 8'h83, "R5 read instr", last_instr, 8'h83);
      bus_byte(8'h00, g, e);
      check(g == rd_val(r0), "R7 first read byte", g, rd_val(r0));
      check(e == 1'b1, "R7 oe during read", e, 1);
      bus_byte(8'h00, g, e);
      check(g == rd_val(r0 + 1), "R7 second read byte", g, rd_val(r0 + 1));
      desel();
      check(n_rd == r0 + 3, "R7 request count", n_rd - r0, 3);
      check(so_oe == 1'b0, "R2 oe off after deselect", so_oe, 0);
   endtask

   task automatic t_hold_read;
      logic [7:0] g; logic s, e;
      int r0 = n_rd;
      sel();
      bus_byte(8'h52, g, e);
      bus_byte(8'h80, g, e);
      for (int i = 7; i >= 4; i--) begin bus_bit(1'b0, s, e); g[i] = s; end
      hold_n = 1'b0;
      wait_clk(HALF);
      check(so_oe == 1'b0, "R8 oe off in hold", so_oe, 0);
      for (int k = 0; k < 3; k++) bus_bit(1'b1, s, e);
      hold_n = 1'b1;
      wait_clk(HALF);
      check(so_oe == 1'b1, "R8 oe back after resume", so_oe, 1);
      for (int i = 3; i >= 0; i--) begin bus_bit(1'b0, s, e); g[i] = s; end
      check(g == rd_val(r0), "R8 read resumes same bit", g, rd_val(r0));
      desel();
   endtask

   task automatic t_hold_write;
      logic [7:0] g; logic s, e;
      logic [7:0] addr = 8'h52;
      int i0 = n_instr;
      sel();
      for (int i = 7; i >= 5; i--) bus_bit(addr[i], s, e);
      hold_n = 1'b0; wait_clk(HALF);
      bus_bit(1'b1, s, e); bus_bit(1'b0, s, e);
      hold_n = 1'b1; wait_clk(HALF);
      for (int i = 4; i >= 0; i--) bus_bit(addr[i], s, e);
      bus_byte(8'h2A, g, e);
      check(n_instr == i0 + 1 && last_instr == 8'h2A, "R8 frame intact after hold", last_instr, 8'h2A);
      desel();
   endtask

   task automatic t_hold_sck_high;
      logic [7:0] g; logic s, e;
      logic [7:0] addr = 8'h52;
      int i0 = n_instr;
      sel();
      for (int i = 7; i >= 4; i--) bus_bit(addr[i], s, e);
      si = addr[3]; wait_clk(HALF); sck = 1'b1; wait_clk(HALF/2);
      hold_n = 1'b0;
      wait_clk(HALF/2); sck = 1'b0;
      for (int i = 2; i >= 0; i--) bus_bit(addr[i], s, e);
      bus_byte(8'h19, g, e);
      check(n_instr == i0 + 1 && last_instr == 8'h19, "R9 hold edge with sck high ignored", last_instr, 8'h19);
      desel();
      si = 1'b0; wait_clk(HALF); sck = 1'b1; wait_clk(HALF/2);
      hold_n = 1'b1; wait_clk(HALF/2); sck = 1'b0; wait_clk(HALF);
   endtask

   task automatic t_abort;
      logic [7:0] g; logic s, e;
      int i0 = n_instr;
      sel();
      bus_byte(8'h52, g, e);
      for (int i = 0; i < 4; i++) bus_bit(1'b1, s, e);
      desel();
      check(n_instr == i0, "R2 partial frame dropped", n_instr - i0, 0);
      sel();
      bus_byte(8'h52, g, e);
      bus_byte(8'h44, g, e);
      desel();
      check(n_instr == i0 + 1 && last_instr == 8'h44, "R2 fresh frame after abort", last_instr, 8'h44);
   endtask

   task automatic t_other_strap;
      logic [7:0] g; logic e;
      int i0 = n_instr;
      strap = 2'd0;
      wait_clk(4);
      sel();
      bus_byte(8'h50, g, e);
      bus_byte(8'h66, g, e);
      desel();
      check(n_instr == i0 + 1 && last_instr == 8'h66, "R4 strap zero match", last_instr, 8'h66);
      strap = 2'd2;
      wait_clk(4);
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset_unarmed();
      t_write();
      t_mismatch(8'h51, "R4 strap mismatch silent");
      t_mismatch(8'hD2, "R4 identifier mismatch silent");
      t_read();
      t_hold_read();
      t_hold_write();
      t_hold_sck_high();
      t_abort();
      t_other_strap();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule